// File: doc/BRIEF.md
# Round-Robin Workgroup Dispatcher

This block hands out the workgroups of a three-dimensional grid to a row of compute units. Software or a command front end first loads the grid: the extent of the grid and the size of one workgroup in each of the three dimensions. It then pulses a pass request. A pass visits every compute unit once, one unit per clock, in round-robin order. The visit starts at a stored rotation pointer, and that pointer moves on after each unit it visits, whether or not the unit takes work.

A unit is given a workgroup when work is still outstanding and the unit raises its ready input. The dispatch appears as a one-cycle strobe on that unit's start line, together with the three-dimensional index and the flat global number of the workgroup being issued. The index walks X first, then Y, then Z. A dimension wraps to zero when its next index times the workgroup size reaches or passes the grid extent. When Z wraps past its extent, the grid is used up and the pass stops at once. At the end of every pass the block reports whether the pass dispatched anything.

Top module: `wgd_dispatch`

## Requirements
- R1: After reset no start strobe is high, `pass_busy`, `pass_done`, `pass_hit` and `grid_left` are low, and the rotation pointer is at unit 0.
- R2: A `pass_start` pulse seen while idle starts a pass that visits one unit per clock over the N units. The unit visited in the first clock after the start is seen drives its strobe in the next cycle. `pass_done` pulses for one cycle together with the outcome of the last visited unit, and `pass_busy` is low from that cycle on.
- R3: The rotation pointer advances by one modulo N for every unit visited, dispatched or not, so the next pass begins at the unit after the last one visited. Loading a grid does not move it.
- R4: At most one bit of `unit_start` is high in any cycle. Bit u is high only when unit u was the visited unit, `grid_left` was high and `unit_ready[u]` was high in the visiting cycle.
- R5: With each strobe, `start_x/y/z` and `start_gid` carry the index and the flat number of the issued workgroup. The flat number starts at 0 and counts up by 1 for each dispatch.
- R6: After a dispatch X increments. When the new X times the X workgroup size is at least the X extent, X becomes 0 and Y increments. The same rule carries Y into Z.
- R7: When the Z carry of a dispatch reaches the Z extent, `grid_left` falls and the pass ends in that same cycle, so `pass_done` comes with the final strobe even if units remain unvisited.
- R8: `pass_hit` is high after a pass if and only if that pass made at least one dispatch. It holds until the next pass starts.
- R9: `grid_load` while idle stores the six sizes, clears the index and the flat number to 0, and raises `grid_left`. If it comes in the same cycle as `pass_start`, the pass uses the new grid.
- R10: `grid_load` and `pass_start` are ignored while a pass is running. The running pass keeps its length and keeps issuing indices from the old grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grid_load | input | 1 | Load new grid sizes (idle only) |
| grid_x | input | DIM_W | Grid extent, X |
| grid_y | input | DIM_W | Grid extent, Y |
| grid_z | input | DIM_W | Grid extent, Z |
| wg_size_x | input | DIM_W | Workgroup size, X |
| wg_size_y | input | DIM_W | Workgroup size, Y |
| wg_size_z | input | DIM_W | Workgroup size, Z |
| pass_start | input | 1 | Begin a dispatch pass (idle only) |
| unit_ready | input | N_UNITS | Per-unit ready, bit u for unit u |
| unit_start | output | N_UNITS | One-cycle start strobe, bit u for unit u |
| start_x | output | DIM_W | X index of the issued workgroup |
| start_y | output | DIM_W | Y index of the issued workgroup |
| start_z | output | DIM_W | Z index of the issued workgroup |
| start_gid | output | GID_W | Flat number of the issued workgroup |
| pass_busy | output | 1 | A pass is running |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |
| pass_hit | output | 1 | Last pass dispatched at least one workgroup |
| grid_left | output | 1 | Workgroups of the loaded grid remain |

## Verification
Two functions can fall in the same cycle. The first is the final dispatch of a grid, which must also end the pass early. The bench builds grids whose workgroup count is not a multiple of the unit count, so that the last workgroup lands in the middle of a pass. It then checks that `pass_done`, the final strobe and the fall of `grid_left` come together, and that the next pass begins at the unit after the last one visited. The second pair is a grid load in the same cycle as a pass start, which must give a pass on the fresh grid. The bench also drives a load and a start together in the middle of a running pass, which must change nothing.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/wgd_rr_ptr.sv
module wgd_rr_ptr #(
    parameter int N_UNITS = 4,
    parameter int PW      = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(N_UNITS - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } rr_s;

    rr_s rr_d, rr_q;

    always_comb begin
        rr_d = rr_q;
        if (adv) begin
            rr_d.ptr = (rr_q.ptr == LAST) ? '0 : rr_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    assign ptr = rr_q.ptr;

    // R3: every visited unit moves the pointer on by one, modulo N
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + PW'(1))));

    // R3: no visit, no movement
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/wgd_grid_walk.sv
module wgd_grid_walk #(
    parameter int DIM_W = 8,
    parameter int GID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIM_W-1:0] gx,
    input  logic [DIM_W-1:0] gy,
    input  logic [DIM_W-1:0] gz,
    input  logic [DIM_W-1:0] wx,
    input  logic [DIM_W-1:0] wy,
    input  logic [DIM_W-1:0] wz,
    input  logic             step,
    output logic [DIM_W-1:0] cur_x,
    output logic [DIM_W-1:0] cur_y,
    output logic [DIM_W-1:0] cur_z,
    output logic [GID_W-1:0] cur_gid,
    output logic             left,
    output logic             grid_fin
);
    localparam int MW = 2 * DIM_W + 1;

    typedef struct packed {
        logic [DIM_W-1:0] gx, gy, gz;
        logic [DIM_W-1:0] wx, wy, wz;
        logic [DIM_W-1:0] x, y, z;
        logic [GID_W-1:0] gid;
        logic             left;
    } walk_s;

    walk_s w_d, w_q;

    logic [MW-1:0] nx_m, ny_m, nz_m;
    logic          x_wrap, y_wrap, z_wrap;

    always_comb begin
        nx_m   = MW'(w_q.x) + MW'(1);
        ny_m   = MW'(w_q.y) + MW'(1);
        nz_m   = MW'(w_q.z) + MW'(1);
        x_wrap = (nx_m * MW'(w_q.wx)) >= MW'(w_q.gx);
        y_wrap = (ny_m * MW'(w_q.wy)) >= MW'(w_q.gy);
        z_wrap = (nz_m * MW'(w_q.wz)) >= MW'(w_q.gz);

        w_d = w_q;
        if (load) begin
            w_d.gx   = gx;
            w_d.gy   = gy;
            w_d.gz   = gz;
            w_d.wx   = wx;
            w_d.wy   = wy;
            w_d.wz   = wz;
            w_d.x    = '0;
            w_d.y    = '0;
            w_d.z    = '0;
            w_d.gid  = '0;
            w_d.left = 1'b1;
        end else if (step && w_q.left) begin
            w_d.gid = w_q.gid + GID_W'(1);
            if (!x_wrap) begin
                w_d.x = nx_m[DIM_W-1:0];
            end else begin
                w_d.x = '0;
                if (!y_wrap) begin
                    w_d.y = ny_m[DIM_W-1:0];
                end else begin
                    w_d.y = '0;
                    w_d.z = nz_m[DIM_W-1:0];
                    if (z_wrap) w_d.left = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign cur_x    = w_q.x;
    assign cur_y    = w_q.y;
    assign cur_z    = w_q.z;
    assign cur_gid  = w_q.gid;
    assign left     = w_q.left;
    assign grid_fin = w_q.left && x_wrap && y_wrap && z_wrap;

    // R5: each accepted step bumps the flat number by exactly one
    p_gid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && left && !load) |=> (cur_gid == $past(cur_gid) + GID_W'(1)));

    // R7: the step that finishes the grid clears the remaining flag
    p_left_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && grid_fin && !load) |=> !left);

    // R9: a load restarts the walk at the origin
    p_load_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (left && cur_x == '0 && cur_y == '0 && cur_z == '0 && cur_gid == '0));
endmodule

// File: rtl/wgd_dispatch.sv
module wgd_dispatch #(
    parameter int N_UNITS = 4,
    parameter int DIM_W   = 8,
    parameter int GID_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grid_load,
    input  logic [DIM_W-1:0]   grid_x,
    input  logic [DIM_W-1:0]   grid_y,
    input  logic [DIM_W-1:0]   grid_z,
    input  logic [DIM_W-1:0]   wg_size_x,
    input  logic [DIM_W-1:0]   wg_size_y,
    input  logic [DIM_W-1:0]   wg_size_z,
    input  logic               pass_start,
    input  logic [N_UNITS-1:0] unit_ready,
    output logic [N_UNITS-1:0] unit_start,
    output logic [DIM_W-1:0]   start_x,
    output logic [DIM_W-1:0]   start_y,
    output logic [DIM_W-1:0]   start_z,
    output logic [GID_W-1:0]   start_gid,
    output logic               pass_busy,
    output logic               pass_done,
    output logic               pass_hit,
    output logic               grid_left
);
    import wgd_pkg::*;

    localparam int PW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
    localparam logic [PW-1:0] LAST = PW'(N_UNITS - 1);

    typedef struct packed {
        phase_e             phase;
        logic [PW-1:0]      tried;
        logic               hit;
        logic               done;
        logic [N_UNITS-1:0] strobe;
        logic [DIM_W-1:0]   sx, sy, sz;
        logic [GID_W-1:0]   sgid;
    } ctl_s;

    ctl_s c_d, c_q;

    logic [PW-1:0]    ptr;
    logic [DIM_W-1:0] cur_x, cur_y, cur_z;
    logic [GID_W-1:0] cur_gid;
    logic             left, grid_fin;
    logic             running, take_load, fire, end_now;

    always_comb begin
        running   = (c_q.phase == PH_RUN);
        take_load = grid_load && !running;
        fire      = running && left && unit_ready[ptr];
        end_now   = running && ((c_q.tried == LAST) || (fire && grid_fin));
    end

    wgd_rr_ptr #(.N_UNITS(N_UNITS), .PW(PW)) i_rr (
        .clk (clk),
        .rst_n (rst_n),
        .adv (running),
        .ptr (ptr)
    );

    wgd_grid_walk #(.DIM_W(DIM_W), .GID_W(GID_W)) i_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_load),
        .gx       (grid_x),
        .gy       (grid_y),
        .gz       (grid_z),
        .wx       (wg_size_x),
        .wy       (wg_size_y),
        .wz       (wg_size_z),
        .step     (fire),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .cur_z    (cur_z),
        .cur_gid  (cur_gid),
        .left     (left),
        .grid_fin (grid_fin)
    );

    always_comb begin
        c_d        = c_q;
        c_d.strobe = '0;
        c_d.done   = 1'b0;
        if (!running) begin
            if (pass_start) begin
                c_d.phase = PH_RUN;
                c_d.tried = '0;
                c_d.hit   = 1'b0;
            end
        end else begin
            c_d.tried = c_q.tried + PW'(1);
            if (fire) begin
                c_d.strobe = N_UNITS'(1) << ptr;
                c_d.sx     = cur_x;
                c_d.sy     = cur_y;
                c_d.sz     = cur_z;
                c_d.sgid   = cur_gid;
                c_d.hit    = 1'b1;
            end
            if (end_now) begin
                c_d.phase = PH_IDLE;
                c_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign unit_start = c_q.strobe;
    assign start_x    = c_q.sx;
    assign start_y    = c_q.sy;
    assign start_z    = c_q.sz;
    assign start_gid  = c_q.sgid;
    assign pass_busy  = running;
    assign pass_done  = c_q.done;
    assign pass_hit   = c_q.hit;
    assign grid_left  = left;

    // R4: never more than one unit started per cycle
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_start));

    // R4: a started unit had its ready input up when it was visited
    p_ready_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_start) |-> ((unit_start & $past(unit_ready)) == unit_start));

    // R2: nothing is started while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_busy |=> (unit_start == '0));

    // R10: a running pass is not restarted by another start request
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_busy && !end_now) |=> (pass_busy && !pass_done));

    // R8: a strobe leaves the hit flag set
    p_hit_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_start) |-> pass_hit);
endmodule

// File: tb/test_wgd_dispatch.sv
`timescale 1ns/1ps
module test_wgd_dispatch;
    localparam int N = 4;
    localparam int DW = 8;
    localparam int GW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grid_load = 1'b0;
    logic [DW-1:0] grid_x = '0, grid_y = '0, grid_z = '0;
    logic [DW-1:0] wg_size_x = '0, wg_size_y = '0, wg_size_z = '0;
    logic          pass_start = 1'b0;
    logic [N-1:0]  unit_ready = '0;
    logic [N-1:0]  unit_start;
    logic [DW-1:0] start_x, start_y, start_z;
    logic [GW-1:0] start_gid;
    logic          pass_busy, pass_done, pass_hit, grid_left;

    always #2.5 clk = ~clk;

    wgd_dispatch #(.N_UNITS(N), .DIM_W(DW), .GID_W(GW)) i_wgd_dispatch (
        .clk(clk), .rst_n(rst_n), .grid_load(grid_load),
        .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
        .wg_size_x(wg_size_x), .wg_size_y(wg_size_y), .wg_size_z(wg_size_z),
        .pass_start(pass_start), .unit_ready(unit_ready),
        .unit_start(unit_start), .start_x(start_x), .start_y(start_y),
        .start_z(start_z), .start_gid(start_gid), .pass_busy(pass_busy),
        .pass_done(pass_done), .pass_hit(pass_hit), .grid_left(grid_left)
    );

    int n_checks = 0;
    int n_fail = 0;

    // bench model
    int m_ptr, m_x, m_y, m_z, m_gid;
    int m_gx, m_gy, m_gz, m_wx, m_wy, m_wz;
    bit m_left;

    typedef struct packed {
        bit           ld;
        bit           poke;
        logic [7:0]   gx, gy, gz, wx, wy, wz;
        logic [N-1:0] rdy;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b1111},
        '{1'b1, 1'b0, 8'd4, 8'd2, 8'd1, 8'd1, 8'd1, 8'd1, 4'b1111},
        '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b0101},
        '{1'b0, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b0010},
        '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b1111},
        '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b1111},
        '{1'b1, 1'b0, 8'd5, 8'd3, 8'd4, 8'd2, 8'd3, 8'd2, 4'b1111},
        '{1'b0, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b1011},
        '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'b1111}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_load(input vec_t v);
        m_gx = v.gx; m_gy = v.gy; m_gz = v.gz;
        m_wx = v.wx; m_wy = v.wy; m_wz = v.wz;
        m_x = 0; m_y = 0; m_z = 0; m_gid = 0; m_left = 1;
    endtask

    // returns 1 when this step finishes the grid
    function automatic bit model_step();
        bit fin;
        fin = 0;
        m_gid++;
        if ((m_x + 1) * m_wx < m_gx) m_x++;
        else begin
            m_x = 0;
            if ((m_y + 1) * m_wy < m_gy) m_y++;
            else begin
                m_y = 0;
                m_z++;
                if (m_z * m_wz >= m_gz) begin m_left = 0; fin = 1; end
            end
        end
        return fin;
    endfunction

    task automatic run_pass(input vec_t v);
        bit hit, ended, fire, fin;
        int u;
        logic [N-1:0] exp_strobe;
        @(negedge clk);
        unit_ready = v.rdy;
        pass_start = 1'b1;
        if (v.ld) begin
            // R9: load and start in the same cycle
            grid_x = v.gx; grid_y = v.gy; grid_z = v.gz;
            wg_size_x = v.wx; wg_size_y = v.wy; wg_size_z = v.wz;
            grid_load = 1'b1;
            model_load(v);
        end
        @(negedge clk);
        pass_start = 1'b0;
        grid_load = 1'b0;
        check(pass_busy == 1'b1, "R2 busy after start", pass_busy, 1);
        hit = 0; ended = 0;
        for (int i = 0; i < N && !ended; i++) begin
            if (v.poke && i == 1) begin
                // R10: load and start while running must be ignored
                grid_x = 8'd1; grid_y = 8'd1; grid_z = 8'd1;
                wg_size_x = 8'd1; wg_size_y = 8'd1; wg_size_z = 8'd1;
                grid_load = 1'b1;
                pass_start = 1'b1;
            end
            u = m_ptr;
            fire = m_left && v.rdy[u];
            exp_strobe = fire ? (N'(1) << u) : '0;
            @(negedge clk);
            grid_load = 1'b0;
            pass_start = 1'b0;
            check(unit_start == exp_strobe, "R4 R3 strobe", int'(unit_start), int'(exp_strobe));
            if (fire) begin
                check(start_x == DW'(m_x), "R6 start_x", start_x, m_x);
                check(start_y == DW'(m_y), "R6 start_y", start_y, m_y);
                check(start_z == DW'(m_z), "R6 start_z", start_z, m_z);
                check(start_gid == GW'(m_gid), "R5 start_gid", start_gid, m_gid);
                fin = model_step();
                hit = 1;
            end else fin = 0;
            m_ptr = (m_ptr + 1) % N;
            ended = (i == N - 1) || fin;
            check(pass_done == ended, "R2 R7 pass_done", pass_done, ended);
            check(grid_left == m_left, "R7 grid_left", grid_left, m_left);
        end
        check(pass_busy == 1'b0, "R2 idle after pass", pass_busy, 0);
        check(pass_hit == hit, "R8 pass_hit", pass_hit, hit);
        @(negedge clk);
        check(pass_done == 1'b0, "R2 done is one cycle", pass_done, 0);
        check(unit_start == '0, "R2 quiet when idle", int'(unit_start), 0);
    endtask

    task automatic check_reset_state();
        check(unit_start == '0, "R1 unit_start", int'(unit_start), 0);
        check(pass_busy == 1'b0, "R1 pass_busy", pass_busy, 0);
        check(pass_done == 1'b0, "R1 pass_done", pass_done, 0);
        check(pass_hit == 1'b0, "R1 pass_hit", pass_hit, 0);
        check(grid_left == 1'b0, "R1 grid_left", grid_left, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0; m_left = 0;
        m_x = 0; m_y = 0; m_z = 0; m_gid = 0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        vec_t d;
        do_reset();
        check_reset_state();
        for (int k = 0; k < NV; k++) begin
            run_pass(VEC[k]);
        end

        // R1: reset puts the pointer back to unit 0 mid-rotation
        m_ptr = 0;
        do_reset();
        check_reset_state();
        d = '{1'b1, 1'b0, 8'd2, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 4'b1111};
        run_pass(d);

        // R9: a separate idle load keeps the pointer where it was (now at 2)
        @(negedge clk);
        grid_x = 8'd3; grid_y = 8'd1; grid_z = 8'd1;
        wg_size_x = 8'd1; wg_size_y = 8'd1; wg_size_z = 8'd1;
        grid_load = 1'b1;
        d = '{1'b1, 1'b0, 8'd3, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 4'b1111};
        model_load(d);
        @(negedge clk);
        grid_load = 1'b0;
        check(grid_left == 1'b1, "R9 grid_left after load", grid_left, 1);
        check(m_ptr == 2, "R3 model pointer", m_ptr, 2);
        d.ld = 1'b0;
        run_pass(d);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule